// File: doc/BRIEF.md
# Power-Good Window Monitor

This block produces the power-good indication of a buck regulator from a handful of digitised status flags: an overvoltage comparator flag, an undervoltage comparator flag, a soft-start completion flag, the regulator enable and a supply-above-power-on-reset flag. Its clock is the switching-cycle clock, so every count it makes is a count of switching cycles. The analog thresholds and the comparator hysteresis sit in front of the block. The overvoltage flag reads high when feedback is above 110% of the reference and the undervoltage flag reads high when feedback is below 90% of it. Each flag releases about 3% back inside its trip point. The open-drain pad sits after the block.

The block's behaviour is asymmetric. Power-good only rises after a full run of valid switching cycles, 1000 by default. A cycle is valid when the output is inside the window, soft-start has completed, enable is high and the supply is above power-on reset. Any invalid cycle drops power-good on the next register update and restarts the qualification from zero. Every flag passes through a two-flop synchroniser before it is used, so the fixed latency from a pin change to the output is the synchroniser depth plus one register.

Top module: `pwrgood_mon`

## Requirements
- R1: While `rst_n` is low, `pg_o` is 0. The first clock edge after release leaves it at 0.
- R2: With every input valid (`en_i`=1, `por_ok_i`=1, `ss_done_i`=1, `ov_i`=0, `uv_i`=0) from a starting point, `pg_o` is still 0 after QUAL_CYCLES+SYNC_STAGES-1 rising edges. It is 1 after QUAL_CYCLES+SYNC_STAGES edges.
- R3: While `ss_done_i` is 0, `pg_o` stays 0 however long the window is valid.
- R4: `ov_i` going to 1 drives `pg_o` to 0 on the (SYNC_STAGES+1)-th rising edge after the change.
- R5: `uv_i` going to 1 drives `pg_o` to 0 with the same latency as R4.
- R6: `en_i` going to 0 drives `pg_o` to 0 with the same latency as R4.
- R7: `por_ok_i` going to 0 drives `pg_o` to 0 with the same latency as R4.
- R8: A single invalid cycle during qualification restarts the count. `pg_o` then rises QUAL_CYCLES+SYNC_STAGES edges after the inputs return to valid, with no credit for earlier cycles.
- R9: After a fault clears, `pg_o` returns to 1 only after the full R2 delay, counted from the clearing.
- R10: The qualification count saturates. Once `pg_o` is 1 with all inputs valid, it stays 1 for any number of further cycles.
- R11: Every input flag passes through SYNC_STAGES flops (default 2). A fault seen SYNC_STAGES edges after its change has not yet lowered `pg_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Switching-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Regulator enable, asynchronous |
| por_ok_i | input | 1 | Supply above power-on-reset threshold, asynchronous |
| ss_done_i | input | 1 | Soft-start ramp completed, asynchronous |
| ov_i | input | 1 | Feedback above upper window limit, asynchronous |
| uv_i | input | 1 | Feedback below lower window limit, asynchronous |
| pg_o | output | 1 | Registered power-good |

## Verification
The bench builds the block with its defaults: a 1000-cycle qualification and a two-flop synchroniser. Every edge count it checks is therefore the real startup and recovery timing: low at edge 1001 and high at edge 1002 after valid inputs appear. A fault must leave the output high at edge 2 and low at edge 3. At this size, the hold check runs well beyond the terminal count, which shows the counter does not wrap. A one-cycle glitch placed halfway through qualification shows that the count restarts and earns no partial credit.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

  typedef struct packed {
    logic en;
    logic por_ok;
    logic ss_done;
    logic ov;
    logic uv;
  } pgm_flags_t;

  localparam int unsigned PGM_FLAG_W = $bits(pgm_flags_t);

  function automatic logic pgm_cycle_ok(input pgm_flags_t f);
    return f.en & f.por_ok & f.ss_done & ~f.ov & ~f.uv;
  endfunction

endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] stage_d;
      if (s == 0) begin : g_first
        always_comb stage_d = async_i;
      end else begin : g_rest
        always_comb stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pgm_qual_cnt.sv
module pgm_qual_cnt #(
  parameter int unsigned QUAL_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_ok,
  output logic qual_met
);

  localparam int unsigned CNT_W = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
  localparam logic [CNT_W-1:0] TERM = CNT_W'(QUAL_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (!sample_ok) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (cnt_q != TERM) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual_met = (cnt_q == TERM);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_ok |=> (cnt_q == '0));

  p_saturate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ok && cnt_q == TERM) |=> (cnt_q == TERM));

endmodule

// File: rtl/pgm_pg_reg.sv
module pgm_pg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_ok,
  input  logic qual_met,
  output logic pg_q
);

  logic pg_d;

  always_comb pg_d = sample_ok & qual_met;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pg_q <= 1'b0;
    else        pg_q <= pg_d;
  end

  p_rise_qualified_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pg_q) |-> $past(qual_met));

endmodule

// File: rtl/pwrgood_mon.sv
module pwrgood_mon
  import pgm_pkg::*;
#(
  parameter int unsigned QUAL_CYCLES = 1000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic por_ok_i,
  input  logic ss_done_i,
  input  logic ov_i,
  input  logic uv_i,
  output logic pg_o
);

  pgm_flags_t flags_a, flags_s;
  logic       sample_ok;
  logic       qual_met;

  always_comb begin
    flags_a.en      = en_i;
    flags_a.por_ok  = por_ok_i;
    flags_a.ss_done = ss_done_i;
    flags_a.ov      = ov_i;
    flags_a.uv      = uv_i;
  end

  pgm_sync #(.WIDTH(PGM_FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (flags_a),
    .sync_o  (flags_s)
  );

  always_comb sample_ok = pgm_cycle_ok(flags_s);

  pgm_qual_cnt #(.QUAL_CYCLES(QUAL_CYCLES)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_ok (sample_ok),
    .qual_met  (qual_met)
  );

  pgm_pg_reg u_pg (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_ok (sample_ok),
    .qual_met  (qual_met),
    .pg_q      (pg_o)
  );

  p_ov_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    flags_s.ov |=> !pg_o);

  p_uv_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flags_s.uv |=> !pg_o);

  p_en_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_s.en |=> !pg_o);

  p_por_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_s.por_ok |=> !pg_o);

  p_ss_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_s.ss_done |=> !pg_o);

endmodule

// File: tb/pwrgood_mon_bench.sv
module pwrgood_mon_bench;

  localparam int unsigned QUAL = 1000;
  localparam int unsigned SYNC = 2;
  localparam int unsigned RISE = QUAL + SYNC;
  localparam int unsigned DROP = SYNC + 1;

  logic clk = 1'b0;
  logic rst_n;
  logic en_i, por_ok_i, ss_done_i, ov_i, uv_i;
  logic pg_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  pwrgood_mon #(.QUAL_CYCLES(QUAL), .SYNC_STAGES(SYNC)) u_pwrgood_mon (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .por_ok_i  (por_ok_i),
    .ss_done_i (ss_done_i),
    .ov_i      (ov_i),
    .uv_i      (uv_i),
    .pg_o      (pg_o)
  );

  task automatic check_pg(input logic exp, input string req);
    n_checks++;
    if (pg_o !== exp) begin
      n_fail++;
      $display("FAIL %s: pg_o=%b expected %b at %0t", req, pg_o, exp, $time);
    end
  endtask

  // waits n rising edges, returns at the following falling edge
  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_all_valid();
    en_i = 1'b1; por_ok_i = 1'b1; ss_done_i = 1'b1; ov_i = 1'b0; uv_i = 1'b0;
  endtask

  // inputs just became valid at a falling edge: check exact rise edge
  task automatic expect_rise(input string req);
    edges(RISE - 1);
    check_pg(1'b0, req);
    edges(1);
    check_pg(1'b1, req);
  endtask

  task automatic expect_drop(input string req);
    edges(SYNC);
    check_pg(1'b1, "R11");
    edges(1);
    check_pg(1'b0, req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_all_valid();
    edges(3);
    check_pg(1'b0, "R1");
    rst_n = 1'b1;
    edges(1);
    check_pg(1'b0, "R1");
    en_i = 1'b0;
    edges(4);
  endtask

  task automatic t_startup_gate();
    en_i = 1'b1; por_ok_i = 1'b1; ov_i = 1'b0; uv_i = 1'b0; ss_done_i = 1'b0;
    edges(RISE + 200);
    check_pg(1'b0, "R3");
    ss_done_i = 1'b1;
    expect_rise("R2");
  endtask

  task automatic t_ov_fault();
    ov_i = 1'b1;
    expect_drop("R4");
    ov_i = 1'b0;
    expect_rise("R9");
  endtask

  task automatic t_uv_fault();
    uv_i = 1'b1;
    expect_drop("R5");
    uv_i = 1'b0;
    expect_rise("R9");
  endtask

  task automatic t_en_off();
    en_i = 1'b0;
    expect_drop("R6");
    en_i = 1'b1;
    expect_rise("R6");
  endtask

  task automatic t_por_loss();
    por_ok_i = 1'b0;
    expect_drop("R7");
    por_ok_i = 1'b1;
    expect_rise("R7");
  endtask

  task automatic t_restart();
    en_i = 1'b0;
    edges(DROP + 2);
    check_pg(1'b0, "R8");
    en_i = 1'b1;
    edges(QUAL / 2);
    uv_i = 1'b1;
    edges(0);
    uv_i = 1'b0;
    expect_rise("R8");
  endtask

  task automatic t_hold();
    edges(3 * QUAL);
    check_pg(1'b1, "R10");
    edges(QUAL + 7);
    check_pg(1'b1, "R10");
  endtask

  initial begin
    en_i = 1'b0; por_ok_i = 1'b0; ss_done_i = 1'b0; ov_i = 1'b0; uv_i = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_startup_gate();
    t_ov_fault();
    t_uv_fault();
    t_en_off();
    t_por_loss();
    t_restart();
    t_hold();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule